// File: doc/BRIEF.md
# Voltage/Temperature Channel Switch Sequencer

This block decides, one conversion at a time, which input a shared converter samples: the voltage channel or the temperature channel. It also marks which results of each conversion can be trusted. A second converter measures current without pause, so every conversion tick yields a current result. The converter that serves voltage and temperature, however, needs several conversions to settle after its input changes. The sequencer follows that settling. It drives the input select and raises a valid flag for each of the current, voltage and temperature results.

Two ways of switching are supported. In the default way the normal channel select is followed, and the result is withheld until the new input has settled. In the fast temperature way the host sets a request bit. The block then takes a single temperature reading that is slotted between voltage readings. This costs one conversion of delay, plus two recovery conversions afterwards that carry only current data.

States: `SQ_RUN` (steady on one channel), `SQ_SET1` and `SQ_SET2` (settling after a default switch), `SQ_FTEMP` (the fast temperature conversion is under way), and `SQ_REC1` and `SQ_REC2` (recovery after the return to voltage). Transitions happen only on a conversion tick:
- run→set1 on a select change;
- run→ftemp on an accepted fast request;
- set1→set2→run;
- ftemp→rec1→rec2→run.
Every other tick in `SQ_RUN` stays in `SQ_RUN`.

Top module: `vt_switch_seq`

## Requirements
- R1: After reset, all valid flags and the error flag are 0, the select is 0 (voltage) and the state is `SQ_RUN`. No flag changes before the first tick.
- R2: `i_valid` is 1 after every conversion tick, whatever the voltage/temperature switching is doing.
- R3: The flags and `mux_sel` change only at a clock edge where `conv_tick` is 1. Between ticks they hold their values, even while the other inputs toggle.
- R4: A default switch works as follows. In `SQ_RUN`, a tick where `chan_sel` (0 = voltage, 1 = temperature) differs from `mux_sel` reports the old channel as valid and moves `mux_sel` to `chan_sel`. The next two ticks report neither voltage nor temperature. The third tick reports the new channel as valid.
- R5: A fast sequence runs as follows. In `SQ_RUN` with `mux_sel` = 0, a tick that sees `fast_req` = 1 (and is armed) reports voltage valid and sets `mux_sel` to 1. The next tick may report temperature and sets `mux_sel` back to 0. The two ticks after that report current only. The tick after those reports voltage valid again.
- R6: `t_valid` at the fast temperature tick is 1 only if `vt_read` pulsed after the request tick and before the temperature tick. Otherwise it is 0.
- R7: A change of `chan_sel` is ignored during settling and during a fast sequence. It takes effect at the first tick in `SQ_RUN`.
- R8: If `fast_req` is still 1 at the last recovery tick, `seq_err` becomes 1 and stays 1 until `fast_req` is 0. No new fast sequence starts until `fast_req` has been seen at 0.
- R9: A fast request wins over a pending select change in the same tick. A fast request is not acted on while `mux_sel` is 1; it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_tick | input | 1 | One-cycle pulse; a conversion has completed |
| fast_req | input | 1 | Host fast temperature request bit |
| chan_sel | input | 1 | Default channel choice: 0 voltage, 1 temperature |
| vt_read | input | 1 | Pulse when the host reads the voltage/temperature result |
| mux_sel | output | 1 | Converter input select: 0 voltage, 1 temperature |
| i_valid | output | 1 | Current result valid |
| v_valid | output | 1 | Voltage result valid |
| t_valid | output | 1 | Temperature result valid |
| seq_err | output | 1 | Fast request bit was not cleared in time |

## Verification
The bench checks that a select change during settling or recovery has no effect until `SQ_RUN`. A design that listened to it early would flip `mux_sel` in the middle of a sequence. It checks that a temperature tick with no read before it gives `t_valid` = 0; a design that forgot the read gate would report a stale temperature. It checks that a request bit left high raises `seq_err` and blocks a second sequence; a design without arming would loop on temperature conversions. It also checks that fast requests wait while the temperature input is selected, and that the switch tick still reports the old channel as valid, which exposes off-by-one settling counts.

// File: rtl/vt_seq_pkg.sv
package vt_seq_pkg;
    typedef enum logic [2:0] {
        SQ_RUN   = 3'd0,
        SQ_SET1  = 3'd1,
        SQ_SET2  = 3'd2,
        SQ_FTEMP = 3'd3,
        SQ_REC1  = 3'd4,
        SQ_REC2  = 3'd5
    } sq_state_t;
endpackage

// File: rtl/vt_read_latch.sv
module vt_read_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_tick,
    input  logic vt_read,
    output logic rd_seen
);
    // Remembers a host read of the result since the last tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_seen <= 1'b0;
        else if (conv_tick) rd_seen <= 1'b0;
        else if (vt_read)   rd_seen <= 1'b1;
    end
endmodule

// File: rtl/vt_fast_guard.sv
module vt_fast_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_req,
    input  logic seq_start,
    input  logic seq_end,
    output logic armed,
    output logic seq_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         armed <= 1'b1;
        else if (!fast_req) armed <= 1'b1;
        else if (seq_start) armed <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   seq_err <= 1'b0;
        else if (seq_end && fast_req) seq_err <= 1'b1;
        else if (!fast_req)           seq_err <= 1'b0;
    end

    // R8: the error clears once the request bit is low
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !fast_req && !seq_end) |=> !seq_err);
    // R8: no sequence starts unless armed
    p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> armed);
endmodule

// File: rtl/vt_switch_seq.sv
module vt_switch_seq
    import vt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_tick,
    input  logic fast_req,
    input  logic chan_sel,
    input  logic vt_read,
    output logic mux_sel,
    output logic i_valid,
    output logic v_valid,
    output logic t_valid,
    output logic seq_err
);
    sq_state_t st, st_nxt;
    logic      rd_seen, armed;
    logic      nx_mux, nx_v, nx_t, start_c;

    vt_read_latch u_rd (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick),
        .vt_read(vt_read), .rd_seen(rd_seen)
    );

    vt_fast_guard u_guard (
        .clk(clk), .rst_n(rst_n), .fast_req(fast_req),
        .seq_start(conv_tick && start_c),
        .seq_end(conv_tick && (st == SQ_REC2)),
        .armed(armed), .seq_err(seq_err)
    );

    always_comb begin
        st_nxt  = st;
        nx_mux  = mux_sel;
        nx_v    = 1'b0;
        nx_t    = 1'b0;
        start_c = 1'b0;
        unique case (st)
            SQ_RUN: begin
                if (fast_req && armed && !mux_sel) begin
                    start_c = 1'b1;
                    nx_v    = 1'b1;
                    nx_mux  = 1'b1;
                    st_nxt  = SQ_FTEMP;
                end else begin
                    nx_v = !mux_sel;
                    nx_t = mux_sel;
                    if (chan_sel != mux_sel) begin
                        nx_mux = chan_sel;
                        st_nxt = SQ_SET1;
                    end
                end
            end
            SQ_SET1:  st_nxt = SQ_SET2;
            SQ_SET2:  st_nxt = SQ_RUN;
            SQ_FTEMP: begin
                nx_t   = rd_seen;
                nx_mux = 1'b0;
                st_nxt = SQ_REC1;
            end
            SQ_REC1:  st_nxt = SQ_REC2;
            SQ_REC2:  st_nxt = SQ_RUN;
            default:  st_nxt = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         st <= SQ_RUN;
        else if (conv_tick) st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_sel <= 1'b0;
            i_valid <= 1'b0;
            v_valid <= 1'b0;
            t_valid <= 1'b0;
        end else if (conv_tick) begin
            mux_sel <= nx_mux;
            i_valid <= 1'b1;
            v_valid <= nx_v;
            t_valid <= nx_t;
        end
    end

    // R2: current data stays valid once ticking
    p_ivalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> i_valid);
    // R3: no change without a tick
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_tick |=> $stable({mux_sel, v_valid, t_valid, i_valid}));
    // R4: voltage and temperature never valid together
    p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(v_valid && t_valid));
    // R5: temperature valid only comes from a conversion on the temperature input
    p_temp_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_valid) |-> $past(mux_sel));
    // R7: select fixed during the settle steps
    p_settle_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_tick && st == SQ_SET1) |=> $stable(mux_sel));
endmodule

// File: tb/vt_switch_seq_test.sv
module vt_switch_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_tick = 1'b0, fast_req = 1'b0, chan_sel = 1'b0, vt_read = 1'b0;
    logic mux_sel, i_valid, v_valid, t_valid, seq_err;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    vt_switch_seq uut (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .fast_req(fast_req),
        .chan_sel(chan_sel), .vt_read(vt_read), .mux_sel(mux_sel),
        .i_valid(i_valid), .v_valid(v_valid), .t_valid(t_valid), .seq_err(seq_err)
    );

    // {fast_req, chan_sel, read, exp_v, exp_t, exp_mux, exp_err}
    localparam logic [6:0] VEC [32] = '{
        7'b000_1000, 7'b001_1000, 7'b101_1010, 7'b101_0100,   // R5 R6
        7'b000_0000, 7'b000_0000, 7'b000_1000, 7'b010_1010,   // R5, R4 switch
        7'b000_0010, 7'b000_0010, 7'b000_0100, 7'b000_0000,   // R7 ignored, R4
        7'b000_0000, 7'b000_1000, 7'b010_1010, 7'b110_0010,   // R4
        7'b110_0010, 7'b110_0110, 7'b100_0100, 7'b100_0000,   // R9 wait on T
        7'b100_0000, 7'b100_1010, 7'b100_0000, 7'b100_0000,   // R6 no read
        7'b100_0001, 7'b100_1001, 7'b000_1000, 7'b110_1010,   // R8, R9 priority
        7'b011_0100, 7'b010_0000, 7'b010_0000, 7'b010_1010    // R7 in fast
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act i/v/t/mux/err=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic fr, input logic cs, input logic rd);
        @(negedge clk);
        fast_req = fr; chan_sel = cs; vt_read = rd;
        @(negedge clk);
        vt_read = 1'b0; conv_tick = 1'b1;
        @(negedge clk);
        conv_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {i_valid, v_valid, t_valid, mux_sel, seq_err}, 5'b00000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {i_valid, v_valid, t_valid, mux_sel, seq_err}, 5'b00000);
        for (int k = 0; k < 32; k++) begin
            do_tick(VEC[k][6], VEC[k][5], VEC[k][4]);
            check($sformatf("R2/R4-R9 vec%0d", k),
                  {i_valid, VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0]} == 5'b0 ? 5'b0 :
                  {i_valid, v_valid, t_valid, mux_sel, seq_err},
                  {1'b1, VEC[k][3:0]});
        end
        // R3: toggle inputs without a tick, nothing moves (mux=1, v=1 now)
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chan_sel = j[0]; vt_read = ~j[0];
        end
        @(negedge clk); vt_read = 1'b0;
        check("R3", {i_valid, v_valid, t_valid, mux_sel, seq_err}, 5'b11010);
        // R1: reset mid run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {i_valid, v_valid, t_valid, mux_sel, seq_err}, 5'b00000);
        rst_n = 1'b1; chan_sel = 1'b0;
        do_tick(1'b0, 1'b0, 1'b0);
        check("R2", {i_valid, v_valid, t_valid, mux_sel, seq_err}, 5'b11000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule